// File: doc/BRIEF.md
# Saturating Motion Delta Accumulator

This block gathers the signed X and Y displacement of each image frame into two internal buffers that are wider than the 8-bit register view. A controller reads them through three read strobes: one for a motion status byte, one for the Y delta and one for the X delta. When a buffer holds more than one byte can express, each delta read returns positive or negative full scale and takes that amount out of the buffer. Repeated reads drain the rest.

A status flag is high while either buffer holds nonzero motion, and an active-low motion pin follows it. A second flag records that a buffer reached its limit and that path data was lost. A write strobe to the status register clears both buffers and both flags. The written byte itself is discarded. A Y delta read also captures the X delta, so the X read that follows reports a value consistent with the Y value just read.

Top module: `motion_delta_accum`

## Requirements
- R1: A delta read strobe returns the buffer's value as 8-bit two's complement (-128 = 0x80 to +127 = 0x7F) on `rd_data`, registered one cycle after the strobe. `rd_data` holds its value between reads.
- R2: When a buffer holds more than +127 or less than -128, a read of that axis returns 0x7F or 0x80 respectively. The remainder stays pending.
- R3: `mot` is high exactly while either buffer is nonzero. It is updated in the same cycle as the buffers.
- R4: `motion_n` is always the inverse of `mot`.
- R5: `ovf` is set in the cycle after a buffer update that would leave the 12-bit signed range.
- R6: Once set, `ovf` stays set until a delta read (Y or X) leaves neither buffer at +2047 or -2048. A write also clears it.
- R7: `wr_motion` clears both buffers, `ovf` and any captured X value. The written data is not used. A frame input in the same cycle is added after the clear and is kept.
- R8: A delta read subtracts exactly the reported amount from that axis buffer.
- R9: The buffers are 12-bit signed and saturate at +2047 and -2048 instead of wrapping.
- R10: When a frame input and a delta read occur in the same cycle, the read reports the value from before the addition. The new input stays in the buffer.
- R11: A Y read captures the X chunk. The next X read returns the captured value even if frames arrive in between, and subtracts that value.
- R12: A status read returns `mot` in bit 7 and `ovf` in bit 4, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | Per-frame displacement valid |
| frame_dx | input | 8 | Signed X displacement of the frame |
| frame_dy | input | 8 | Signed Y displacement of the frame |
| rd_motion | input | 1 | Read strobe, status byte |
| rd_dy | input | 1 | Read strobe, Y delta |
| rd_dx | input | 1 | Read strobe, X delta |
| wr_motion | input | 1 | Write strobe, status byte (clears) |
| rd_data | output | 8 | Registered read data |
| mot | output | 1 | Motion pending flag |
| ovf | output | 1 | Overflow flag |
| motion_n | output | 1 | Active-low motion pin |

## Verification
The accumulation is driven with several input patterns, each aimed at a different possible fault:
- A single small mixed-sign frame shows whether sign handling and per-axis routing are correct.
- A multi-frame total of a few hundred counts forces the full-scale chunked drain and shows whether the remainder is kept.
- Runs of 21 frames in each direction push the buffers to their positive and negative limits. Draining them completely reveals whether they wrap or saturate at exactly +2047 and -2048, and when the overflow flag clears.
- Frames that arrive in the same cycle as a read or a write, and frames that arrive between a Y read and its X read, separate the ordering rules for subtract-then-add, clear-then-add and the captured X value.

// File: rtl/mda_pkg.sv
package mda_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DY   = 2'd2,
    SEL_DX   = 2'd3
  } rd_sel_e;

  localparam int STAT_MOT_BIT = 7;
  localparam int STAT_OVF_BIT = 4;
  localparam int NUM_AXES     = 2;
  localparam int AXIS_Y       = 0;
  localparam int AXIS_X       = 1;
endpackage

// File: rtl/mda_axis.sv
module mda_axis #(
  parameter int ACC_W = 12,
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [IN_W-1:0]  add_val,
  input  logic             take_en,
  input  logic [OUT_W-1:0] take_val,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] nxt_o,
  output logic [OUT_W-1:0] chunk_o,
  output logic             sat_o,
  output logic             nxt_lim_o
);
  localparam int SUM_W = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'((2 ** (ACC_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SUM_LO = -SUM_HI - SUM_W'(1);
  localparam logic signed [ACC_W-1:0] ACC_HI = SUM_HI[ACC_W-1:0];
  localparam logic signed [ACC_W-1:0] ACC_LO = SUM_LO[ACC_W-1:0];
  localparam logic signed [ACC_W-1:0] CHK_HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] CHK_LO = -CHK_HI - ACC_W'(1);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [IN_W-1:0]  add_s;
  logic signed [OUT_W-1:0] take_s;
  logic signed [SUM_W-1:0] base, sub_term, add_term, sum;

  assign add_s  = add_val;
  assign take_s = take_val;

  always_comb begin
    base     = clr ? '0 : SUM_W'(acc_q);
    sub_term = '0;
    add_term = '0;
    if (take_en && !clr) sub_term = SUM_W'(take_s);
    if (add_en)          add_term = SUM_W'(add_s);
    sum   = base - sub_term + add_term;
    sat_o = 1'b0;
    if (sum > SUM_HI) begin
      acc_d = ACC_HI;
      sat_o = 1'b1;
    end else if (sum < SUM_LO) begin
      acc_d = ACC_LO;
      sat_o = 1'b1;
    end else begin
      acc_d = sum[ACC_W-1:0];
    end
  end

  always_comb begin
    if (acc_q > CHK_HI)      chunk_o = {1'b0, {(OUT_W-1){1'b1}}};
    else if (acc_q < CHK_LO) chunk_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                     chunk_o = acc_q[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign acc_o     = acc_q;
  assign nxt_o     = acc_d;
  assign nxt_lim_o = (acc_d == ACC_HI) || (acc_d == ACC_LO);

  AST_SAT_HOLD_HI: assert property (@(posedge clk) disable iff (rst)
    (acc_q == ACC_HI && add_en && !add_val[IN_W-1] && !take_en && !clr) |=> (acc_q == ACC_HI)); // R9
  AST_SAT_HOLD_LO: assert property (@(posedge clk) disable iff (rst)
    (acc_q == ACC_LO && add_en && add_val[IN_W-1] && !take_en && !clr) |=> (acc_q == ACC_LO)); // R9
endmodule

// File: rtl/mda_readback.sv
module mda_readback
  import mda_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             rd_stat,
  input  logic             rd_y,
  input  logic             rd_x,
  input  logic [OUT_W-1:0] chunk_y,
  input  logic [OUT_W-1:0] chunk_x,
  input  logic             mot,
  input  logic             ovf,
  output logic [OUT_W-1:0] rd_data,
  output logic             take_y_en,
  output logic [OUT_W-1:0] take_y_val,
  output logic             take_x_en,
  output logic [OUT_W-1:0] take_x_val,
  output logic             delta_rd
);
  rd_sel_e          sel;
  logic [OUT_W-1:0] snap_q;
  logic             snap_vld_q;
  logic [OUT_W-1:0] stat_byte;
  logic [OUT_W-1:0] data_d;

  always_comb begin
    sel = SEL_NONE;
    if (!clr) begin
      if (rd_stat)   sel = SEL_STAT;
      else if (rd_y) sel = SEL_DY;
      else if (rd_x) sel = SEL_DX;
    end
  end

  always_comb begin
    stat_byte               = '0;
    stat_byte[STAT_MOT_BIT] = mot;
    stat_byte[STAT_OVF_BIT] = ovf;
  end

  assign take_y_en  = (sel == SEL_DY);
  assign take_y_val = chunk_y;
  assign take_x_en  = (sel == SEL_DX);
  assign take_x_val = snap_vld_q ? snap_q : chunk_x;
  assign delta_rd   = take_y_en || take_x_en;

  always_comb begin
    case (sel)
      SEL_STAT: data_d = stat_byte;
      SEL_DY:   data_d = chunk_y;
      SEL_DX:   data_d = take_x_val;
      default:  data_d = rd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
    end else begin
      rd_data <= data_d;
      if (clr) begin
        snap_vld_q <= 1'b0;
      end else if (sel == SEL_DY) begin
        snap_q     <= chunk_x;
        snap_vld_q <= 1'b1;
      end else if (sel == SEL_DX) begin
        snap_vld_q <= 1'b0;
      end
    end
  end

  AST_Y_READ_VALUE: assert property (@(posedge clk) disable iff (rst)
    (rd_y && !rd_stat && !clr) |=> (rd_data == $past(chunk_y))); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rd_stat && !rd_y && !rd_x) |=> $stable(rd_data)); // R1
endmodule

// File: rtl/mda_flags.sv
module mda_flags #(
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sat_any,
  input  logic             delta_rd,
  input  logic             lim_any,
  input  logic [ACC_W-1:0] nxt_y,
  input  logic [ACC_W-1:0] nxt_x,
  output logic             mot,
  output logic             ovf,
  output logic             motion_n
);
  logic pend_d;
  logic ovf_d;

  assign pend_d = (nxt_y != '0) || (nxt_x != '0);

  always_comb begin
    if (sat_any)                 ovf_d = 1'b1;
    else if (clr)                ovf_d = 1'b0;
    else if (delta_rd && !lim_any) ovf_d = 1'b0;
    else                         ovf_d = ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mot      <= 1'b0;
      ovf      <= 1'b0;
      motion_n <= 1'b1;
    end else begin
      mot      <= pend_d;
      ovf      <= ovf_d;
      motion_n <= !pend_d;
    end
  end

  AST_PIN_TRACKS_MOT: assert property (@(posedge clk) disable iff (rst)
    motion_n == !mot); // R4
  AST_OVF_ON_SAT: assert property (@(posedge clk) disable iff (rst)
    sat_any |=> ovf); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !delta_rd && !clr) |=> ovf); // R6
endmodule

// File: rtl/motion_delta_accum.sv
module motion_delta_accum
  import mda_pkg::*;
#(
  parameter int ACC_W = 12,
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_vld,
  input  logic [IN_W-1:0]  frame_dx,
  input  logic [IN_W-1:0]  frame_dy,
  input  logic             rd_motion,
  input  logic             rd_dy,
  input  logic             rd_dx,
  input  logic             wr_motion,
  output logic [OUT_W-1:0] rd_data,
  output logic             mot,
  output logic             ovf,
  output logic             motion_n
);
  logic [ACC_W-1:0] acc   [NUM_AXES];
  logic [ACC_W-1:0] nxt   [NUM_AXES];
  logic [OUT_W-1:0] chunk [NUM_AXES];
  logic [IN_W-1:0]  din   [NUM_AXES];
  logic [OUT_W-1:0] tval  [NUM_AXES];
  logic             ten   [NUM_AXES];
  logic [NUM_AXES-1:0] sat, lim;
  logic             delta_rd;

  assign din[AXIS_Y] = frame_dy;
  assign din[AXIS_X] = frame_dx;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    mda_axis #(
      .ACC_W(ACC_W),
      .IN_W (IN_W),
      .OUT_W(OUT_W)
    ) i_axis (
      .clk      (clk),
      .rst      (rst),
      .clr      (wr_motion),
      .add_en   (frame_vld),
      .add_val  (din[a]),
      .take_en  (ten[a]),
      .take_val (tval[a]),
      .acc_o    (acc[a]),
      .nxt_o    (nxt[a]),
      .chunk_o  (chunk[a]),
      .sat_o    (sat[a]),
      .nxt_lim_o(lim[a])
    );
  end

  mda_readback #(
    .OUT_W(OUT_W)
  ) i_readback (
    .clk       (clk),
    .rst       (rst),
    .clr       (wr_motion),
    .rd_stat   (rd_motion),
    .rd_y      (rd_dy),
    .rd_x      (rd_dx),
    .chunk_y   (chunk[AXIS_Y]),
    .chunk_x   (chunk[AXIS_X]),
    .mot       (mot),
    .ovf       (ovf),
    .rd_data   (rd_data),
    .take_y_en (ten[AXIS_Y]),
    .take_y_val(tval[AXIS_Y]),
    .take_x_en (ten[AXIS_X]),
    .take_x_val(tval[AXIS_X]),
    .delta_rd  (delta_rd)
  );

  mda_flags #(
    .ACC_W(ACC_W)
  ) i_flags (
    .clk     (clk),
    .rst     (rst),
    .clr     (wr_motion),
    .sat_any (|sat),
    .delta_rd(delta_rd),
    .lim_any (|lim),
    .nxt_y   (nxt[AXIS_Y]),
    .nxt_x   (nxt[AXIS_X]),
    .mot     (mot),
    .ovf     (ovf),
    .motion_n(motion_n)
  );

  AST_MOT_MATCHES_ACC: assert property (@(posedge clk) disable iff (rst)
    mot == ((acc[AXIS_Y] != '0) || (acc[AXIS_X] != '0))); // R3
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_motion && !frame_vld) |=> (!mot && !ovf)); // R7
endmodule

// File: tb/test_motion_delta_accum.sv
module test_motion_delta_accum;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_vld = 1'b0;
  logic [7:0] frame_dx = '0;
  logic [7:0] frame_dy = '0;
  logic       rd_motion = 1'b0;
  logic       rd_dy = 1'b0;
  logic       rd_dx = 1'b0;
  logic       wr_motion = 1'b0;
  logic [7:0] rd_data;
  logic       mot, ovf, motion_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  motion_delta_accum i_motion_delta_accum (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_dx(frame_dx),
    .frame_dy(frame_dy), .rd_motion(rd_motion), .rd_dy(rd_dy), .rd_dx(rd_dx),
    .wr_motion(wr_motion), .rd_data(rd_data), .mot(mot), .ovf(ovf),
    .motion_n(motion_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus; outputs are sampled at the following negedge
  task automatic step(input logic fv, input int dx, input int dy,
                      input logic rm, input logic ry, input logic rx, input logic wr);
    frame_vld = fv; frame_dx = 8'(dx); frame_dy = 8'(dy);
    rd_motion = rm; rd_dy = ry; rd_dx = rx; wr_motion = wr;
    @(negedge clk);
    frame_vld = 1'b0; frame_dx = '0; frame_dy = '0;
    rd_motion = 1'b0; rd_dy = 1'b0; rd_dx = 1'b0; wr_motion = 1'b0;
  endtask

  function automatic int sx8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  task automatic t_reset();
    check("R3 reset mot", mot, 0);
    check("R4 reset motion_n", motion_n, 1);
    check("R6 reset ovf", ovf, 0);
    check("R1 reset rd_data", rd_data, 0);
  endtask

  task automatic t_small();
    step(1, 5, -3, 0, 0, 0, 0);
    check("R3 mot after frame", mot, 1);
    check("R4 pin low", motion_n, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    check("R12 status byte", rd_data, 8'h80);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R1 dy negative", rd_data, 8'hFD);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R1 dx positive", rd_data, 8'h05);
    check("R8 drained mot", mot, 0);
    check("R4 pin high", motion_n, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R1 rd_data held", rd_data, 8'h05);
  endtask

  task automatic t_chunks();
    for (int i = 0; i < 3; i++) step(1, 100, (i < 2) ? -100 : 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R2 dy neg full scale", rd_data, 8'h80);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R2 dx pos full scale", rd_data, 8'h7F);
    check("R2 remainder pending", mot, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R8 dy remainder", rd_data, 8'hB8);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R2 dx full again", rd_data, 8'h7F);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R8 dy empty", rd_data, 8'h00);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R8 dx remainder", rd_data, 8'h2E);
    check("R3 drained", mot, 0);
  endtask

  task automatic t_sat(input int d, input int exp_total);
    int total = 0;
    for (int i = 0; i < 21; i++) step(1, d, 0, 0, 0, 0, 0);
    check("R5 ovf set", ovf, 1);
    step(0, 0, 0, 1, 0, 0, 0);
    check("R12 status with ovf", rd_data, 8'h90);
    step(1, d, 0, 0, 0, 0, 0);
    check("R6 ovf held without read", ovf, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R6 ovf held at limit", ovf, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    total += sx8(rd_data);
    check("R6 ovf cleared", ovf, 0);
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0);
      total += sx8(rd_data);
    end
    check("R9 saturated total", total, exp_total);
    check("R9 drained", mot, 0);
  endtask

  task automatic t_write();
    step(1, 50, 60, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    check("R7 clear mot", mot, 0);
    check("R7 clear pin", motion_n, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R7 dy zero", rd_data, 0);
    step(1, 3, 4, 0, 0, 0, 1);
    check("R7 frame kept", mot, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R7 dy after clear", rd_data, 4);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R7 dx after clear", rd_data, 3);
  endtask

  task automatic t_same_cycle();
    step(1, 0, 10, 0, 0, 0, 0);
    step(1, 0, 5, 0, 1, 0, 0);
    check("R10 pre-add value", rd_data, 10);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R10 new input kept", rd_data, 5);
    check("R10 empty", mot, 0);
  endtask

  task automatic t_capture();
    step(1, 7, 9, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    check("R11 dy", rd_data, 9);
    step(1, 20, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R11 captured dx", rd_data, 7);
    step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    check("R11 later dx", rd_data, 20);
    check("R11 drained", mot, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_small();
    t_chunks();
    t_sat(100, 2047);
    t_sat(-100, -2048);
    t_write();
    t_same_cycle();
    t_capture();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule